// File: doc/BRIEF.md
# Doubleword Memory Module Controller

This block serves 64-bit doubleword reads and writes from a processor-side request bus. The storage behind it is a module of eight byte-wide DRAM chips. Every chip receives the same command at the same moment: a precharge, a row activate or a column access, with one shared address bus. Each chip holds one fixed byte lane of the doubleword. On a write the controller spreads the doubleword across the eight lanes. On a read it assembles the eight returned bytes back into one word.

The request address has two fields. The upper field selects a row and the lower field selects a column. After an access the controller leaves its row open and remembers which row that is. A later request to the same row goes straight to the column access. A request to a different row first closes the open row with a precharge and then activates the new row.

Reads and writes are taken one at a time through a valid/ready handshake. A write carries only its address on the request channel. Its data word arrives later on a separate write-data channel, and the column write is issued only once both have arrived. Read data returns with a one-cycle response pulse.

Top module: `dword_mem_ctrl`

## Requirements
- R1: The request address splits into a row field `req_addr[ROW_W+COL_W-1:COL_W]` and a column field `req_addr[COL_W-1:0]`. An activate presents the row on `dram_addr` and a column access presents the column on the low `COL_W` bits of `dram_addr`.
- R2: A read returns, in byte k of `rsp_data` (bits 8k+7 down to 8k), the byte that chip k drives on `dram_dq_in[8k+7:8k]`. Chip 0 carries bits 7:0 and chip 7 carries bits 63:56.
- R3: During a write column access, `dram_we` and `dram_dq_oe` are high and lane k of `dram_dq_out` carries byte k of the write word. `dram_dq_oe` is never high outside a write column access.
- R4: A column access is issued only while a row is open, and at least `T_RCD` cycles after the activate that opened it.
- R5: The first access after reset issues an activate with no precharge before it.
- R6: A request whose row equals the open row issues only a column access, with no precharge and no activate.
- R7: A request to a row other than the open one issues a precharge, then an activate at least `T_RP` cycles later, then the column access. An activate never occurs while a row is open.
- R8: Read data is sampled `T_CL` cycles after the read column access and is presented on `rsp_data` with a `rsp_valid` pulse exactly one cycle long.
- R9: After a write address is accepted, `wd_ready` is high until the data word is taken, and no column write is issued before that.
- R10: Only one request is in service at a time. `req_ready` falls in the cycle after a request is accepted and stays low until the request has finished.
- R11: At most one of `dram_pre`, `dram_act`, `dram_col` is high in any cycle.
- R12: After reset, `req_ready` is high, `wd_ready` and `rsp_valid` are low, no command is issued and no row is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Doubleword address (row high, column low) |
| wd_valid | input | 1 | Write data present |
| wd_ready | output | 1 | Controller waits for write data |
| wd_data | input | LANES*LANE_W | Write doubleword |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_data | output | LANES*LANE_W | Read doubleword |
| dram_pre | output | 1 | Precharge command to all chips |
| dram_act | output | 1 | Row activate command to all chips |
| dram_col | output | 1 | Column access command to all chips |
| dram_we | output | 1 | Column access is a write |
| dram_addr | output | max(ROW_W,COL_W) | Shared row/column address |
| dram_dq_oe | output | 1 | Controller drives the data lanes |
| dram_dq_out | output | LANES*LANE_W | Write lanes, lane k to chip k |
| dram_dq_in | input | LANES*LANE_W | Read lanes, lane k from chip k |

## Verification
Embedded properties watch the command stream on every cycle. They check that only one command is issued at a time, that a column access needs an open row, that no activate lands on an open row, and that the precharge-to-activate and activate-to-column gaps meet their minimums. They also check that a write column waits for its data, that the response is a single pulse, and that the request channel stays busy while a request is in service. Some behaviour only the bench's scenarios can show: the correct lane order, correct data through a write followed by a read, and the choice between hit, conflict and first-access paths for a given sequence of addresses, which the bench checks by counting precharges and activates per request against its own record of the open row.

// File: rtl/dwm_pkg.sv
package dwm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WDATA,
    ST_PRE,
    ST_ACT,
    ST_COL,
    ST_GAP,
    ST_RDWAIT
  } dwm_state_e;

  // Upper field of the doubleword address: the row index.
  function automatic logic [31:0] row_part(input logic [31:0] addr, input int unsigned col_w);
    return addr >> col_w;
  endfunction

  // Lower field of the doubleword address: the column index.
  function automatic logic [31:0] col_part(input logic [31:0] addr, input int unsigned col_w);
    return addr & ((32'd1 << col_w) - 32'd1);
  endfunction

  // A gap of N cycles between two commands needs N-1 cycles of waiting,
  // spent in the gap state whose counter counts down to zero.
  function automatic int gap_load(input int gap);
    return gap - 2;
  endfunction

endpackage

// File: rtl/dwm_row_track.sv
module dwm_row_track #(
  parameter int ROW_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             open_i,
  input  logic             close_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [ROW_W-1:0] q_row_i,
  output logic             open_valid_o,
  output logic [ROW_W-1:0] open_row_o,
  output logic             hit_o,
  output logic             conflict_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_valid_o <= 1'b0;
      open_row_o   <= '0;
    end else if (close_i) begin
      open_valid_o <= 1'b0;
    end else if (open_i) begin
      open_valid_o <= 1'b1;
      open_row_o   <= row_i;
    end
  end

  assign hit_o      = open_valid_o && (open_row_o == q_row_i);
  assign conflict_o = open_valid_o && (open_row_o != q_row_i);

  AST_OPEN_RECORDS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    open_i |=> (open_valid_o && open_row_o == $past(row_i))); // R6
  AST_CLOSE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    close_i |=> !open_valid_o); // R7
  AST_ACT_ON_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    open_i |-> !open_valid_o); // R7

endmodule

// File: rtl/dwm_lanes.sv
module dwm_lanes #(
  parameter int LANES  = 8,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    oe_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  output logic [LANES*LANE_W-1:0] dq_out_o,
  input  logic                    cap_i,
  input  logic [LANES*LANE_W-1:0] dq_in_i,
  output logic [LANES*LANE_W-1:0] rdata_o
);

  // Chip k owns lane k: bits k*LANE_W and up of the doubleword.
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [LANE_W-1:0] rd_byte;

    assign dq_out_o[k*LANE_W +: LANE_W] = oe_i ? wdata_i[k*LANE_W +: LANE_W] : '0;

    always_ff @(posedge clk) begin
      if (!rst_n)     rd_byte <= '0;
      else if (cap_i) rd_byte <= dq_in_i[k*LANE_W +: LANE_W];
    end

    assign rdata_o[k*LANE_W +: LANE_W] = rd_byte;
  end

endmodule

// File: rtl/dwm_seq.sv
module dwm_seq
  import dwm_pkg::*;
#(
  parameter int ROW_W  = 4,
  parameter int COL_W  = 4,
  parameter int DW     = 64,
  parameter int T_RP   = 2,
  parameter int T_RCD  = 2,
  parameter int T_CL   = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic                  wd_valid,
  output logic                  wd_ready,
  input  logic [DW-1:0]         wd_data,
  output logic                  rsp_valid,
  output logic                  cmd_pre,
  output logic                  cmd_act,
  output logic                  cmd_col,
  output logic                  cmd_we,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] cmd_addr,
  output logic [DW-1:0]         wdata_o,
  output logic                  cap_o,
  output logic [ROW_W-1:0]      act_row_o,
  output logic [ROW_W-1:0]      q_row_o,
  input  logic                  hit_i,
  input  logic                  conflict_i,
  input  logic                  open_valid_i
);

  localparam int AW    = ROW_W + COL_W;
  localparam int CMD_AW = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int TMAX  = (T_RP > T_RCD) ? ((T_RP > T_CL) ? T_RP : T_CL)
                                        : ((T_RCD > T_CL) ? T_RCD : T_CL);
  localparam int WCW   = $clog2(TMAX + 1) + 1;
  localparam int SCW   = $clog2(T_RP + T_RCD + 4) + 1;

  dwm_state_e       state;
  dwm_state_e       gap_next;
  logic [WCW-1:0]   wait_left;
  logic [AW-1:0]    addr_q;
  logic             wr_q;
  logic [DW-1:0]    wdata_q;

  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic [ROW_W-1:0] row_in;
  logic             take_req;
  logic             take_wd;
  logic             rd_done;

  assign row_q  = ROW_W'(row_part(32'(addr_q), COL_W));
  assign col_q  = COL_W'(col_part(32'(addr_q), COL_W));
  assign row_in = ROW_W'(row_part(32'(req_addr), COL_W));

  // Path for a request once its address (and write data) is in hand.
  function automatic dwm_state_e route(input logic hit, input logic conflict);
    if (hit)           return ST_COL;
    else if (conflict) return ST_PRE;
    else               return ST_ACT;
  endfunction

  assign take_req = (state == ST_IDLE) && req_valid;
  assign take_wd  = (state == ST_WDATA) && wd_valid;
  assign rd_done  = (state == ST_RDWAIT) && (wait_left == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      gap_next  <= ST_IDLE;
      wait_left <= '0;
      addr_q    <= '0;
      wr_q      <= 1'b0;
      wdata_q   <= '0;
      rsp_valid <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            addr_q <= req_addr;
            wr_q   <= req_write;
            state  <= req_write ? ST_WDATA : route(hit_i, conflict_i);
          end
        end
        ST_WDATA: begin
          if (wd_valid) begin
            wdata_q <= wd_data;
            state   <= route(hit_i, conflict_i);
          end
        end
        ST_PRE: begin
          if (T_RP > 1) begin
            state     <= ST_GAP;
            gap_next  <= ST_ACT;
            wait_left <= WCW'(gap_load(T_RP));
          end else begin
            state <= ST_ACT;
          end
        end
        ST_ACT: begin
          if (T_RCD > 1) begin
            state     <= ST_GAP;
            gap_next  <= ST_COL;
            wait_left <= WCW'(gap_load(T_RCD));
          end else begin
            state <= ST_COL;
          end
        end
        ST_COL: begin
          if (wr_q) begin
            state <= ST_IDLE;
          end else begin
            state     <= ST_RDWAIT;
            wait_left <= WCW'(T_CL - 1);
          end
        end
        ST_GAP: begin
          if (wait_left == '0) state <= gap_next;
          else                 wait_left <= wait_left - 1'b1;
        end
        ST_RDWAIT: begin
          if (wait_left == '0) begin
            rsp_valid <= 1'b1;
            state     <= ST_IDLE;
          end else begin
            wait_left <= wait_left - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Commands decode straight from the state register.
  assign req_ready = (state == ST_IDLE);
  assign wd_ready  = (state == ST_WDATA);
  assign cmd_pre   = (state == ST_PRE);
  assign cmd_act   = (state == ST_ACT);
  assign cmd_col   = (state == ST_COL);
  assign cmd_we    = cmd_col && wr_q;
  assign cap_o     = rd_done;
  assign wdata_o   = wdata_q;
  assign act_row_o = row_q;
  assign q_row_o   = (state == ST_IDLE) ? row_in : row_q;

  always_comb begin
    cmd_addr = '0;
    if (cmd_act)      cmd_addr = CMD_AW'(row_q);
    else if (cmd_col) cmd_addr = CMD_AW'(col_q);
  end

  // Observation counters for the timing properties.
  logic [SCW-1:0] since_act;
  logic [SCW-1:0] since_pre;
  logic           wd_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_act <= '1;
      since_pre <= '1;
      wd_seen   <= 1'b0;
    end else begin
      if (cmd_act)              since_act <= SCW'(1);
      else if (since_act != '1) since_act <= since_act + 1'b1;
      if (cmd_pre)              since_pre <= SCW'(1);
      else if (since_pre != '1) since_pre <= since_pre + 1'b1;
      if (take_wd)              wd_seen <= 1'b1;
      else if (cmd_we)          wd_seen <= 1'b0;
    end
  end

  AST_COL_NEEDS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_col |-> open_valid_i); // R4
  AST_RCD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_col |-> (since_act >= SCW'(T_RCD))); // R4
  AST_RP_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_act |-> (since_pre >= SCW'(T_RP))); // R7
  AST_WRITE_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we |-> wd_seen); // R9
  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R8
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    take_req |=> !req_ready); // R10
  AST_ONE_COMMAND: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_pre, cmd_act, cmd_col})); // R11

endmodule

// File: rtl/dword_mem_ctrl.sv
module dword_mem_ctrl #(
  parameter int ROW_W  = 4,
  parameter int COL_W  = 4,
  parameter int LANES  = 8,
  parameter int LANE_W = 8,
  parameter int T_RP   = 2,
  parameter int T_RCD  = 2,
  parameter int T_CL   = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic                          req_write,
  input  logic [ROW_W+COL_W-1:0]        req_addr,
  input  logic                          wd_valid,
  output logic                          wd_ready,
  input  logic [LANES*LANE_W-1:0]       wd_data,
  output logic                          rsp_valid,
  output logic [LANES*LANE_W-1:0]       rsp_data,
  output logic                          dram_pre,
  output logic                          dram_act,
  output logic                          dram_col,
  output logic                          dram_we,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr,
  output logic                          dram_dq_oe,
  output logic [LANES*LANE_W-1:0]       dram_dq_out,
  input  logic [LANES*LANE_W-1:0]       dram_dq_in
);

  localparam int DW = LANES * LANE_W;

  logic [ROW_W-1:0] act_row;
  logic [ROW_W-1:0] q_row;
  logic [ROW_W-1:0] open_row;
  logic             open_valid;
  logic             row_hit;
  logic             row_conflict;
  logic             cap;
  logic [DW-1:0]    wdata;

  dwm_seq #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DW(DW),
    .T_RP(T_RP), .T_RCD(T_RCD), .T_CL(T_CL)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr),
    .wd_valid(wd_valid), .wd_ready(wd_ready), .wd_data(wd_data),
    .rsp_valid(rsp_valid),
    .cmd_pre(dram_pre), .cmd_act(dram_act), .cmd_col(dram_col),
    .cmd_we(dram_we), .cmd_addr(dram_addr),
    .wdata_o(wdata), .cap_o(cap),
    .act_row_o(act_row), .q_row_o(q_row),
    .hit_i(row_hit), .conflict_i(row_conflict), .open_valid_i(open_valid)
  );

  dwm_row_track #(.ROW_W(ROW_W)) u_rows (
    .clk(clk), .rst_n(rst_n),
    .open_i(dram_act), .close_i(dram_pre),
    .row_i(act_row), .q_row_i(q_row),
    .open_valid_o(open_valid), .open_row_o(open_row),
    .hit_o(row_hit), .conflict_o(row_conflict)
  );

  assign dram_dq_oe = dram_we;

  dwm_lanes #(.LANES(LANES), .LANE_W(LANE_W)) u_lanes (
    .clk(clk), .rst_n(rst_n),
    .oe_i(dram_we), .wdata_i(wdata), .dq_out_o(dram_dq_out),
    .cap_i(cap), .dq_in_i(dram_dq_in), .rdata_o(rsp_data)
  );

  AST_OPEN_ROW_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!dram_act && !dram_pre) |=> $stable(open_row)); // R6

endmodule

// File: tb/dword_mem_ctrl_test.sv
`timescale 1ns/1ps
module dword_mem_ctrl_test;

  localparam int ROW_W = 4;
  localparam int COL_W = 4;
  localparam int AW    = ROW_W + COL_W;
  localparam int DEPTH = 1 << AW;
  localparam int T_RP  = 2;
  localparam int T_RCD = 2;
  localparam int T_CL  = 2;
  localparam int LIMIT = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic        wd_valid = 1'b0;
  logic        wd_ready;
  logic [63:0] wd_data = '0;
  logic        rsp_valid;
  logic [63:0] rsp_data;
  logic        dram_pre, dram_act, dram_col, dram_we, dram_dq_oe;
  logic [3:0]  dram_addr;
  logic [63:0] dram_dq_out;
  logic [63:0] dram_dq_in;

  dword_mem_ctrl #(
    .ROW_W(ROW_W), .COL_W(COL_W), .LANES(8), .LANE_W(8),
    .T_RP(T_RP), .T_RCD(T_RCD), .T_CL(T_CL)
  ) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .wd_valid(wd_valid), .wd_ready(wd_ready),
    .wd_data(wd_data), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .dram_pre(dram_pre), .dram_act(dram_act), .dram_col(dram_col),
    .dram_we(dram_we), .dram_addr(dram_addr), .dram_dq_oe(dram_dq_oe),
    .dram_dq_out(dram_dq_out), .dram_dq_in(dram_dq_in)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] seed_byte(input int k, input int a);
    return 8'((a * 7 + k * 29 + 3) & 255);
  endfunction

  // Eight byte-wide chip models sharing one command bus.
  logic [7:0]  chip_mem [8][DEPTH];
  logic        chip_open;
  logic [ROW_W-1:0] chip_row;
  logic [63:0] rd_pipe [T_CL];
  logic [63:0] gath;

  always_comb begin
    for (int k = 0; k < 8; k++)
      gath[k*8 +: 8] = chip_mem[k][{chip_row, dram_addr[COL_W-1:0]}];
  end

  assign dram_dq_in = rd_pipe[T_CL-1];

  always @(posedge clk) begin
    if (!rst_n) begin
      chip_open <= 1'b0;
      chip_row  <= '0;
      for (int a = 0; a < DEPTH; a++)
        for (int k = 0; k < 8; k++) chip_mem[k][a] <= seed_byte(k, a);
      for (int i = 0; i < T_CL; i++) rd_pipe[i] <= '0;
    end else begin
      if (dram_pre) chip_open <= 1'b0;
      if (dram_act) begin
        chip_open <= 1'b1;
        chip_row  <= dram_addr[ROW_W-1:0];
      end
      if (dram_col && dram_we)
        for (int k = 0; k < 8; k++)
          chip_mem[k][{chip_row, dram_addr[COL_W-1:0]}] <= dram_dq_out[k*8 +: 8];
      rd_pipe[0] <= (dram_col && !dram_we) ? gath : 64'h0BAD_0BAD_0BAD_0BAD;
      for (int i = 1; i < T_CL; i++) rd_pipe[i] <= rd_pipe[i-1];
    end
  end

  // Scoreboard state shared by driver and monitor.
  logic [63:0] exp_q [$];
  logic [63:0] ref_mem [DEPTH];
  logic [ROW_W-1:0] cur_row;
  logic [COL_W-1:0] cur_col;
  logic [63:0] cur_wdata;
  int pre_cnt = 0, act_cnt = 0, col_cnt = 0;
  int last_pre = 0, last_act = 0;
  bit pre_seen = 0, act_seen = 0, prev_rsp = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (dram_pre) begin
        pre_cnt++; last_pre = cyc; pre_seen = 1;
      end
      if (dram_act) begin
        act_cnt++;
        check(dram_addr == 4'(cur_row), "R1", "activate row", 64'(dram_addr), 64'(cur_row));
        check(!chip_open, "R7", "activate on open row", 64'(chip_open), 64'd0);
        if (pre_seen)
          check((cyc - last_pre) >= T_RP, "R7", "precharge-to-activate gap",
                64'(cyc - last_pre), 64'(T_RP));
        pre_seen = 0; last_act = cyc; act_seen = 1;
      end
      if (dram_col) begin
        col_cnt++;
        check(dram_addr[COL_W-1:0] == cur_col, "R1", "column address",
              64'(dram_addr), 64'(cur_col));
        check(chip_open, "R4", "column with no open row", 64'(chip_open), 64'd1);
        if (act_seen)
          check((cyc - last_act) >= T_RCD, "R4", "activate-to-column gap",
                64'(cyc - last_act), 64'(T_RCD));
        act_seen = 0;
        if (dram_we) begin
          check(dram_dq_oe == 1'b1, "R3", "drive enable on write", 64'(dram_dq_oe), 64'd1);
          check(dram_dq_out == cur_wdata, "R3", "write lanes", dram_dq_out, cur_wdata);
        end
      end
      if (dram_dq_oe && !(dram_col && dram_we))
        check(1'b0, "R3", "drive enable outside write", 64'd1, 64'd0);
      if ((32'(dram_pre) + 32'(dram_act) + 32'(dram_col)) > 1)
        check(1'b0, "R11", "several commands in one cycle",
              64'({dram_pre, dram_act, dram_col}), 64'd0);
      if (rsp_valid) begin
        check(!prev_rsp, "R8", "response wider than one cycle", 64'(prev_rsp), 64'd0);
        if (exp_q.size() == 0) begin
          check(1'b0, "R8", "unexpected response", rsp_data, 64'd0);
        end else begin
          logic [63:0] e;
          e = exp_q.pop_front();
          check(rsp_data == e, "R2", "read doubleword", rsp_data, e);
        end
      end
      prev_rsp = rsp_valid;
    end
  end

  // Driver
  bit bench_open = 0;
  logic [ROW_W-1:0] bench_row = '0;
  int hits_exp = 0, miss_exp = 0;

  task automatic expect_path(input logic [AW-1:0] a, output int pre_e, output int act_e);
    logic [ROW_W-1:0] r;
    r = a[AW-1:COL_W];
    if (bench_open && r == bench_row) begin
      pre_e = 0; act_e = 0; hits_exp++;
    end else begin
      pre_e = bench_open ? 1 : 0; act_e = 1; miss_exp++;
    end
    bench_open = 1; bench_row = r;
  endtask

  task automatic send_req(input logic [AW-1:0] a, input bit wr);
    cur_row = a[AW-1:COL_W];
    cur_col = a[COL_W-1:0];
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a;
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    req_valid = 1'b0;
    @(negedge clk);
    check(!req_ready, "R10", "ready low after accept", 64'(req_ready), 64'd0);
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!req_ready || exp_q.size() != 0);
  endtask

  task automatic check_path(input string tag, input int p0, input int a0,
                            input int pre_e, input int act_e);
    check(pre_cnt - p0 == pre_e, tag, "precharges for request", 64'(pre_cnt - p0), 64'(pre_e));
    check(act_cnt - a0 == act_e, tag, "activates for request", 64'(act_cnt - a0), 64'(act_e));
  endtask

  task automatic do_read(input logic [AW-1:0] a, input string tag);
    int pe, ae, p0, a0;
    expect_path(a, pe, ae);
    p0 = pre_cnt; a0 = act_cnt;
    exp_q.push_back(ref_mem[a]);
    send_req(a, 1'b0);
    wait_done();
    check_path(tag, p0, a0, pe, ae);
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [63:0] d,
                          input int hold, input string tag);
    int pe, ae, p0, a0, c0;
    expect_path(a, pe, ae);
    p0 = pre_cnt; a0 = act_cnt; c0 = col_cnt;
    cur_wdata = d;
    send_req(a, 1'b1);
    for (int i = 0; i < hold; i++) begin
      check(wd_ready == 1'b1, "R9", "waiting for write data", 64'(wd_ready), 64'd1);
      check(col_cnt == c0, "R9", "column before data", 64'(col_cnt - c0), 64'd0);
      check(!req_ready, "R10", "busy while waiting for data", 64'(req_ready), 64'd0);
      @(negedge clk);
    end
    wd_valid = 1'b1; wd_data = d;
    while (!wd_ready) @(negedge clk);
    @(posedge clk); #1;
    wd_valid = 1'b0;
    wait_done();
    ref_mem[a] = d;
    check_path(tag, p0, a0, pe, ae);
    for (int k = 0; k < 8; k++)
      check(chip_mem[k][a] == d[k*8 +: 8], "R3", $sformatf("chip %0d byte", k),
            64'(chip_mem[k][a]), 64'(d[k*8 +: 8]));
  endtask

  initial begin
    for (int a = 0; a < DEPTH; a++)
      for (int k = 0; k < 8; k++) ref_mem[a][k*8 +: 8] = seed_byte(k, a);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12: reset state
    check(req_ready == 1'b1, "R12", "ready after reset", 64'(req_ready), 64'd1);
    check(wd_ready == 1'b0, "R12", "no data wait after reset", 64'(wd_ready), 64'd0);
    check(rsp_valid == 1'b0, "R12", "no response after reset", 64'(rsp_valid), 64'd0);
    check({dram_pre, dram_act, dram_col} == 3'b000, "R12", "no command after reset",
          64'({dram_pre, dram_act, dram_col}), 64'd0);

    do_read(8'h23, "R5");             // first access: activate only
    do_read(8'h21, "R6");             // same row: column only
    do_read(8'h2F, "R6");
    do_read(8'h5A, "R7");             // other row: precharge + activate
    do_write(8'h5B, 64'h0123_4567_89AB_CDEF, 4, "R6");
    do_read(8'h5B, "R6");
    do_write(8'h10, 64'hFEDC_BA98_7654_3210, 0, "R7");
    do_read(8'h10, "R6");
    do_read(8'hFF, "R7");
    do_read(8'h00, "R7");
    do_write(8'h0F, 64'hA5A5_5A5A_0F0F_F0F0, 2, "R6");
    do_read(8'h0F, "R6");
    for (int i = 0; i < 24; i++) begin
      logic [AW-1:0] a;
      a = AW'((i * 37 + (i / 3) * 5) & 8'hFF);
      if (i % 5 == 2) do_write(a, {32'(i) * 32'h01010101, ~(32'(i) * 32'h10203)}, i % 3, "R3");
      else            do_read(a, "R2");
    end

    check(act_cnt == miss_exp, "R6", "total activates equal row misses",
          64'(act_cnt), 64'(miss_exp));
    $display("row hits %0d row misses %0d", hits_exp, miss_exp);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (LIMIT) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog run did not finish actual=%0d expected<%0d", LIMIT, LIMIT);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule